// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block watches the two ports of a shared 1K x 8 memory. In every clock cycle it checks whether both ports are enabled at the same address. When they are, it gives the contested word to one port and drives an active-low BUSY flag to the other port. It also produces a per-port write strobe for the array. That strobe is withheld from a port while that port is held off, so the losing port cannot corrupt the word its neighbour owns. While BUSY holds a port off, the block also freezes that port's read data. The port sees the value it read before the hold, not a word that is changing under the other port's write.

Ownership follows arrival order. A port that was already enabled at the address in the previous cycle is the earlier arrival and keeps the word. When both ports arrive in the same cycle, the left port wins. The owner is held in a three-state machine with the states OWN_NONE, OWN_LEFT and OWN_RIGHT, and it has three transitions:

- grant-left, from OWN_NONE to OWN_LEFT, on a tie or on a left-first collision;
- grant-right, from OWN_NONE to OWN_RIGHT, on a right-first collision;
- release, from either owner state back to OWN_NONE, when the match ends.

Each port has a small read-hold machine with two states. RD_LIVE passes memory data through. RD_HELD repeats the last shown value. A strap input selects slave mode, in which the BUSY flags come from outside and only gate writes and read hold.

Top module: `dpc_arbiter`

## Requirements
- R1: With slave_mode=0, the two busy_n outputs are never low in the same cycle. The busy_in_n inputs have no effect on any output.
- R2: A port is "settled" when, in the previous cycle, its ce_n was low and its address was the same as now. A collision exists when both ce_n are low and the two addresses are equal. If a collision begins (there was no owner in the previous cycle) and exactly one port is settled, that port keeps access and the other port's busy_n goes low in the same cycle.
- R3: If a collision begins and neither port is settled, the left port keeps access and r_busy_n goes low in the same cycle.
- R4: While the collision persists, the owner does not change, whatever either port does with rw_n.
- R5: In master mode, busy_n is low only during a collision. Both flags return high in the first cycle in which the addresses differ or either ce_n is high.
- R6: A port's wr_en is high exactly when its ce_n is low, its rw_n is low (low means write) and its busy_n output is high.
- R7: With slave_mode=1, each busy_n output equals that port's busy_in_n. The internal address compare does not affect any output, and a low busy_in_n blocks that port's wr_en.
- R8: Read hold starts when a port's busy_n goes low in a cycle in which its ce_n, rw_n and address all equal their previous-cycle values. rdata then repeats the value it showed in the previous cycle, and keeps repeating it while busy_n stays low and those three inputs stay unchanged. In every other case rdata equals mem_rdata.
- R9: While rst_n is low (synchronous), both busy_n outputs are high even with a collision on the inputs. All history is cleared, so in the first cycle after reset neither port counts as settled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous reset, active low |
| slave_mode | input | 1 | 1 = take BUSY from busy_in_n; static, changed only under reset |
| l_ce_n | input | 1 | left chip enable, active low |
| l_rw_n | input | 1 | left read/write, low = write |
| l_addr | input | ADDR_W | left word address |
| l_mem_rdata | input | DATA_W | left read data from the array |
| l_busy_in_n | input | 1 | external left BUSY, used in slave mode |
| r_ce_n | input | 1 | right chip enable, active low |
| r_rw_n | input | 1 | right read/write, low = write |
| r_addr | input | ADDR_W | right word address |
| r_mem_rdata | input | DATA_W | right read data from the array |
| r_busy_in_n | input | 1 | external right BUSY, used in slave mode |
| l_busy_n | output | 1 | BUSY to the left port, active low |
| r_busy_n | output | 1 | BUSY to the right port, active low |
| l_wr_en | output | 1 | left write strobe to the array |
| r_wr_en | output | 1 | right write strobe to the array |
| l_rdata | output | DATA_W | left read data, possibly held |
| r_rdata | output | DATA_W | right read data, possibly held |

## Verification
Collision onset can fall in the same cycle as the losing port's own write request, so the BUSY decision and the write block must both act in that cycle. The bench provokes this with directed sequences in which the second port arrives with rw_n already low. In slave mode, a BUSY edge can coincide with a toggle of the port's rw_n or address, and the toggle must win over the start of a hold. Both overlaps also arise often in long random runs over a four-word address space. A behavioural model judges every cycle by comparing BUSY, write strobes and read data against the arrival history it keeps.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
    localparam int NPORT = 2;
    localparam int PL    = 0;
    localparam int PR    = 1;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef enum logic {
        RD_LIVE = 1'b0,
        RD_HELD = 1'b1
    } rd_state_e;
endpackage

// File: rtl/dpc_port_track.sv
module dpc_port_track #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              rw_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              active,
    output logic              settled,
    output logic              changed
);
    logic              p_act;
    logic              p_rw;
    logic [ADDR_W-1:0] p_addr;

    assign active  = ~ce_n;
    assign settled = p_act & (p_addr == addr);
    assign changed = (p_act != active) | (p_addr != addr) | (p_rw != rw_n);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_act  <= 1'b0;
            p_rw   <= 1'b1;
            p_addr <= '0;
        end else begin
            p_act  <= active;
            p_rw   <= rw_n;
            p_addr <= addr;
        end
    end
endmodule

// File: rtl/dpc_owner_fsm.sv
module dpc_owner_fsm
    import dpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic settled_l,
    input  logic settled_r,
    output logic busy_l_n,
    output logic busy_r_n
);
    owner_e state_q;
    owner_e state_d;

    always_comb begin
        state_d = state_q;
        if (!rst_n) begin
            state_d = OWN_NONE;
        end else begin
            unique case (state_q)
                OWN_NONE: begin
                    if (match) begin
                        state_d = (settled_r && !settled_l) ? OWN_RIGHT : OWN_LEFT;
                    end
                end
                OWN_LEFT: begin
                    if (!match) state_d = OWN_NONE;
                end
                OWN_RIGHT: begin
                    if (!match) state_d = OWN_NONE;
                end
                default: state_d = OWN_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    always_comb begin
        busy_l_n = (state_d != OWN_RIGHT);
        busy_r_n = (state_d != OWN_LEFT);
    end
endmodule

// File: rtl/dpc_read_hold.sv
module dpc_read_hold
    import dpc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_n,
    input  logic              changed,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] rdata
);
    rd_state_e         state_q;
    rd_state_e         state_d;
    logic              busy_seen_q;
    logic [DATA_W-1:0] last_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_LIVE: begin
                if (!busy_n && !busy_seen_q && !changed) state_d = RD_HELD;
            end
            RD_HELD: begin
                if (busy_n || changed) state_d = RD_LIVE;
            end
            default: state_d = RD_LIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= RD_LIVE;
            busy_seen_q <= 1'b0;
            last_q      <= '0;
        end else begin
            state_q     <= state_d;
            busy_seen_q <= ~busy_n;
            last_q      <= rdata;
        end
    end

    always_comb begin
        rdata = (state_d == RD_HELD) ? last_q : mem_rdata;
    end
endmodule

// File: rtl/dpc_arbiter.sv
module dpc_arbiter
    import dpc_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              l_ce_n,
    input  logic              l_rw_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_mem_rdata,
    input  logic              l_busy_in_n,
    input  logic              r_ce_n,
    input  logic              r_rw_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_mem_rdata,
    input  logic              r_busy_in_n,
    output logic              l_busy_n,
    output logic              r_busy_n,
    output logic              l_wr_en,
    output logic              r_wr_en,
    output logic [DATA_W-1:0] l_rdata,
    output logic [DATA_W-1:0] r_rdata
);
    logic [NPORT-1:0]  ce_n_v;
    logic [NPORT-1:0]  rw_n_v;
    logic [NPORT-1:0]  bin_v;
    logic [NPORT-1:0]  act_v;
    logic [NPORT-1:0]  set_v;
    logic [NPORT-1:0]  chg_v;
    logic [NPORT-1:0]  arb_busy_v;
    logic [NPORT-1:0]  busy_v;
    logic [NPORT-1:0]  wr_v;
    logic [ADDR_W-1:0] addr_v [NPORT];
    logic [DATA_W-1:0] mrd_v  [NPORT];
    logic [DATA_W-1:0] rd_v   [NPORT];
    logic              match;
    logic              fsm_bl_n;
    logic              fsm_br_n;

    assign ce_n_v     = {r_ce_n, l_ce_n};
    assign rw_n_v     = {r_rw_n, l_rw_n};
    assign bin_v      = {r_busy_in_n, l_busy_in_n};
    assign addr_v[PL] = l_addr;
    assign addr_v[PR] = r_addr;
    assign mrd_v[PL]  = l_mem_rdata;
    assign mrd_v[PR]  = r_mem_rdata;

    assign match = act_v[PL] & act_v[PR] & (addr_v[PL] == addr_v[PR]);

    dpc_owner_fsm u_owner (
        .clk       (clk),
        .rst_n     (rst_n),
        .match     (match),
        .settled_l (set_v[PL]),
        .settled_r (set_v[PR]),
        .busy_l_n  (fsm_bl_n),
        .busy_r_n  (fsm_br_n)
    );

    assign arb_busy_v = {fsm_br_n, fsm_bl_n};

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        dpc_port_track #(.ADDR_W(ADDR_W)) u_track (
            .clk     (clk),
            .rst_n   (rst_n),
            .ce_n    (ce_n_v[g]),
            .rw_n    (rw_n_v[g]),
            .addr    (addr_v[g]),
            .active  (act_v[g]),
            .settled (set_v[g]),
            .changed (chg_v[g])
        );

        assign busy_v[g] = slave_mode ? bin_v[g] : arb_busy_v[g];
        assign wr_v[g]   = act_v[g] & ~rw_n_v[g] & busy_v[g];

        dpc_read_hold #(.DATA_W(DATA_W)) u_hold (
            .clk       (clk),
            .rst_n     (rst_n),
            .busy_n    (busy_v[g]),
            .changed   (chg_v[g]),
            .mem_rdata (mrd_v[g]),
            .rdata     (rd_v[g])
        );
    end

    assign l_busy_n = busy_v[PL];
    assign r_busy_n = busy_v[PR];
    assign l_wr_en  = wr_v[PL];
    assign r_wr_en  = wr_v[PR];
    assign l_rdata  = rd_v[PL];
    assign r_rdata  = rd_v[PR];
endmodule

// File: rtl/dpc_arbiter_chk.sv
module dpc_arbiter_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slave_mode,
    input logic              l_ce_n,
    input logic              l_rw_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_busy_in_n,
    input logic              r_ce_n,
    input logic              r_rw_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_busy_in_n,
    input logic              l_busy_n,
    input logic              r_busy_n,
    input logic              l_wr_en,
    input logic              r_wr_en
);
    logic hit;
    assign hit = !l_ce_n && !r_ce_n && (l_addr == r_addr);

    a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !slave_mode |-> (l_busy_n || r_busy_n));

    a_r2_right_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && hit && $past(l_busy_n) && $past(r_busy_n)
         && !$past(r_ce_n) && ($past(r_addr) == r_addr)
         && !(!$past(l_ce_n) && ($past(l_addr) == l_addr))) |-> !l_busy_n);

    a_r3_tie_left: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && hit && $past(l_busy_n) && $past(r_busy_n)
         && !(!$past(l_ce_n) && ($past(l_addr) == l_addr))
         && !(!$past(r_ce_n) && ($past(r_addr) == r_addr))) |-> (!r_busy_n && l_busy_n));

    a_r4_keep_left: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && hit && !r_busy_n) |=> (!hit || !r_busy_n));

    a_r4_keep_right: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && hit && !l_busy_n) |=> (!hit || !l_busy_n));

    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && !hit) |-> (l_busy_n && r_busy_n));

    a_r6_left_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        l_wr_en |-> (!l_ce_n && !l_rw_n && l_busy_n));

    a_r6_right_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        r_wr_en |-> (!r_ce_n && !r_rw_n && r_busy_n));

    a_r7_slave_left: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode && !l_busy_in_n) |-> (!l_busy_n && !l_wr_en));

    a_r7_slave_right: assert property (@(posedge clk) disable iff (!rst_n)
        (slave_mode && !r_busy_in_n) |-> (!r_busy_n && !r_wr_en));
endmodule

bind dpc_arbiter dpc_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .slave_mode  (slave_mode),
    .l_ce_n      (l_ce_n),
    .l_rw_n      (l_rw_n),
    .l_addr      (l_addr),
    .l_busy_in_n (l_busy_in_n),
    .r_ce_n      (r_ce_n),
    .r_rw_n      (r_rw_n),
    .r_addr      (r_addr),
    .r_busy_in_n (r_busy_in_n),
    .l_busy_n    (l_busy_n),
    .r_busy_n    (r_busy_n),
    .l_wr_en     (l_wr_en),
    .r_wr_en     (r_wr_en)
);

// File: tb/sim_dpc_arbiter.sv
`timescale 1ns/100ps
module sim_dpc_arbiter;
    localparam int AW = 10;
    localparam int DW = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n, mode;
    logic          ce_n [2];
    logic          rw_n [2];
    logic          bin  [2];
    logic [AW-1:0] ad   [2];
    logic [DW-1:0] mrd  [2];
    logic          o_busy_l, o_busy_r, o_wr_l, o_wr_r;
    logic [DW-1:0] o_rd_l, o_rd_r;

    dpc_arbiter #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .slave_mode(mode),
        .l_ce_n(ce_n[0]), .l_rw_n(rw_n[0]), .l_addr(ad[0]),
        .l_mem_rdata(mrd[0]), .l_busy_in_n(bin[0]),
        .r_ce_n(ce_n[1]), .r_rw_n(rw_n[1]), .r_addr(ad[1]),
        .r_mem_rdata(mrd[1]), .r_busy_in_n(bin[1]),
        .l_busy_n(o_busy_l), .r_busy_n(o_busy_r),
        .l_wr_en(o_wr_l), .r_wr_en(o_wr_r),
        .l_rdata(o_rd_l), .r_rdata(o_rd_r)
    );

    // reference model state
    int            owner;
    logic          pact  [2];
    logic          prw   [2];
    logic [AW-1:0] paddr [2];
    logic          hold  [2];
    logic          bprev [2];
    logic [DW-1:0] last  [2];
    int            own_n;
    logic          e_low [2];
    logic          e_hold[2];
    logic          e_wr  [2];
    logic [DW-1:0] e_rd  [2];
    string         tag_b;
    int            vectors = 0;
    int            miscmp  = 0;
    bit            done    = 0;

    task automatic model_reset();
        owner = 0;
        for (int p = 0; p < 2; p++) begin
            pact[p] = 0; prw[p] = 1; paddr[p] = '0;
            hold[p] = 0; bprev[p] = 0; last[p] = '0;
        end
    endtask

    task automatic eval();
        logic match, st0, st1;
        match = !ce_n[0] && !ce_n[1] && (ad[0] == ad[1]);
        st0 = pact[0] && (paddr[0] == ad[0]);
        st1 = pact[1] && (paddr[1] == ad[1]);
        if (!rst_n) begin own_n = 0; tag_b = "R9"; end
        else if (!match) begin own_n = 0; tag_b = (owner != 0) ? "R5" : "R1"; end
        else if (owner != 0) begin own_n = owner; tag_b = "R4"; end
        else if (st1 && !st0) begin own_n = 2; tag_b = "R2"; end
        else if (st0 && !st1) begin own_n = 1; tag_b = "R2"; end
        else begin own_n = 1; tag_b = "R3"; end
        if (mode && rst_n) tag_b = "R7";
        for (int p = 0; p < 2; p++) begin
            logic chg;
            if (mode) e_low[p] = !bin[p];
            else      e_low[p] = (p == 0) ? (own_n == 2) : (own_n == 1);
            e_wr[p] = !ce_n[p] && !rw_n[p] && !e_low[p];
            chg = (pact[p] != !ce_n[p]) || (paddr[p] != ad[p]) || (prw[p] != rw_n[p]);
            e_hold[p] = e_low[p] && !chg && (hold[p] || !bprev[p]);
            e_rd[p] = e_hold[p] ? last[p] : mrd[p];
        end
    endtask

    task automatic cmp(string tag, string what, logic [DW-1:0] got, logic [DW-1:0] exp);
        if (got !== exp) begin
            miscmp++;
            $display("FAIL %s %s at %0t: got %h expected %h", tag, what, $time, got, exp);
        end
    endtask

    task automatic check();
        eval();
        vectors++;
        cmp(tag_b, "l_busy_n", {7'd0, o_busy_l}, {7'd0, !e_low[0]});
        cmp(tag_b, "r_busy_n", {7'd0, o_busy_r}, {7'd0, !e_low[1]});
        cmp(mode ? "R7" : "R6", "l_wr_en", {7'd0, o_wr_l}, {7'd0, e_wr[0]});
        cmp(mode ? "R7" : "R6", "r_wr_en", {7'd0, o_wr_r}, {7'd0, e_wr[1]});
        cmp("R8", "l_rdata", o_rd_l, e_rd[0]);
        cmp("R8", "r_rdata", o_rd_r, e_rd[1]);
    endtask

    task automatic update();
        if (!rst_n) model_reset();
        else begin
            owner = own_n;
            for (int p = 0; p < 2; p++) begin
                pact[p] = !ce_n[p]; prw[p] = rw_n[p]; paddr[p] = ad[p];
                hold[p] = e_hold[p]; bprev[p] = e_low[p]; last[p] = e_rd[p];
            end
        end
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            #1;
            check();
            @(posedge clk);
            update();
            @(negedge clk);
            mrd[0] = mrd[0] + 8'h13;
            mrd[1] = mrd[1] + 8'h29;
        end
    endtask

    task automatic drive(int p, logic ce, logic rw, logic [AW-1:0] a);
        ce_n[p] = ce; rw_n[p] = rw; ad[p] = a;
    endtask

    initial begin
        model_reset();
        rst_n = 0; mode = 0;
        mrd[0] = 8'h00; mrd[1] = 8'h80;
        bin[0] = 1; bin[1] = 1;
        drive(0, 0, 1, 10'h155); drive(1, 0, 1, 10'h155);
        @(negedge clk);
        tick(3);                              // R9: collision under reset
        rst_n = 1;
        drive(0, 1, 1, 10'h155); drive(1, 1, 1, 10'h155);
        tick(2);
        // R3 tie, R6 write gating, R4 persistence
        drive(0, 0, 1, 10'h155); drive(1, 0, 1, 10'h155); tick();
        drive(0, 0, 0, 10'h155); drive(1, 0, 0, 10'h155); tick(2);
        drive(0, 0, 1, 10'h155); tick();
        drive(0, 1, 1, 10'h155); tick();      // R5 release on CE
        drive(1, 1, 1, 10'h155); tick();
        // R2 right first
        drive(1, 0, 1, 10'h020); tick(2);
        drive(0, 0, 0, 10'h020); tick(3);
        drive(0, 0, 1, 10'h020); tick();      // R4 rw toggle
        drive(0, 0, 1, 10'h021); tick();      // R5 release on address
        drive(0, 0, 0, 10'h020); tick(2);     // R2 again
        drive(1, 1, 1, 10'h020); tick();
        drive(0, 1, 1, 10'h020); tick();
        // R2 left first via address, boundary words
        drive(0, 0, 1, 10'h3FF); drive(1, 0, 1, 10'h3FE); tick(2);
        drive(1, 0, 1, 10'h3FF); tick(2);
        drive(1, 0, 0, 10'h3FF); tick(2);
        drive(0, 0, 1, 10'h000); tick();
        drive(1, 0, 0, 10'h000); tick(2);
        drive(0, 1, 1, 10'h000); drive(1, 1, 1, 10'h000); tick();
        // slave mode: R7 and R8
        rst_n = 0; mode = 1; tick(2);
        rst_n = 1; tick();
        drive(0, 0, 1, 10'h005); tick(2);
        bin[0] = 0; tick(3);                  // R8 hold
        drive(0, 0, 0, 10'h005); tick(2);     // R8 release on rw, R7 block
        bin[0] = 1; tick();
        drive(1, 0, 0, 10'h005); tick(2);     // R7 compare ignored
        bin[1] = 0; drive(0, 0, 1, 10'h005); tick(2);
        bin[0] = 0; tick(2);
        drive(0, 0, 1, 10'h006); tick();      // R8 release on address
        bin[0] = 1; bin[1] = 1; tick();
        // random phases in both modes
        for (int m = 0; m < 2; m++) begin
            rst_n = 0; mode = m[0];
            drive(0, 1, 1, 0); drive(1, 1, 1, 0); bin[0] = 1; bin[1] = 1;
            tick(2);
            rst_n = 1;
            for (int k = 0; k < 3000; k++) begin
                for (int p = 0; p < 2; p++) begin
                    drive(p, ($urandom_range(3) == 0), $urandom_range(1) == 1,
                          10'($urandom_range(3)));
                    bin[p] = mode ? ($urandom_range(2) != 0) : ($urandom_range(1) == 1);
                end
                tick();
            end
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin
        #(5 * 150000);
        if (!done) begin
            miscmp++;
            $display("FAIL watchdog expired: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
            $finish;
        end
    end
endmodule